// File: doc/BRIEF.md
# Command Stream Decoder

This block walks a command buffer held in a word-addressed memory and turns it into a stream of method writes for a downstream consumer. It reads one 32-bit word at a time from the byte address held in its get pointer, and keeps going until that pointer reaches the put pointer supplied from outside. Each word it reads is either a control-flow word (a jump, a legacy jump, a call or a return), a method header, or a data word that belongs to the header before it.

A method header loads the method state: a 13-bit method byte address, a 3-bit subchannel, an 11-bit word count and a flag that selects whether the address stays fixed from word to word. The words that follow are data words. Each one is offered to the consumer on a valid/ready handshake, together with the current method address, subchannel and flag. The decoder keeps one subroutine level: a single saved return address and an active flag. Any fault is stored as a 3-bit error code. A fault suspends the decoder until reset.

The get pointer starts at zero after reset. The caller loads the memory, drives the put pointer and the buffer length, and raises the enable input. The read port has a latency of one cycle. The stall input from downstream stops a new word from being fetched. The outputs expose the last header word, the last data word, the jump shadow address and the data-word counter.

Top module: `cmdstream_decoder`

## Requirements
- R1: After reset, get_ptr is 0, err_code is 0, suspended, sub_active, m_valid, mem_rd_en and busy are all 0, and data_count is 0.
- R2: No word is fetched and get_ptr does not change while enable is 0, while stall is 1, while suspended is 1, or while get_ptr equals put_ptr.
- R3: When a fetch would start and get_ptr is not below buf_len, err_code becomes 4 (protection), suspended is set, and get_ptr keeps its value.
- R4: Outside a method, a word with (w & 0xE0000003) == 0x20000000 is a legacy jump to w & 0x1FFFFFFF. Any other word whose bits 1:0 are 01 is a jump to w & 0xFFFFFFFC. For both, jmp_shadow receives the address of the word after the jump.
- R5: A word with bits 1:0 equal to 10 is a call to w & 0xFFFFFFFC. It saves the following address and sets sub_active. A call made while sub_active is set gives err_code 1 and leaves get_ptr on the call word. The word 0x00020000 is a return. With sub_active set, it reloads get_ptr from the saved address and clears sub_active. Without it, it gives err_code 2 and get_ptr moves past the word.
- R6: A word with (w & 0xE0030003) == 0 starts incrementing methods. One equal to 0x40000000 starts non-incrementing methods (m_nonincr = 1). In both cases the method address is w & 0x1FFC, the subchannel is w[15:13], the count is w[28:18], and data_count is cleared. A header with count 0 produces no output.
- R7: Each data word goes out once on m_data, with the method address, subchannel and type in force for it. After the word is accepted, the count drops by one and data_count rises by one. For incrementing methods the address then advances by 4, wrapping within 13 bits.
- R8: While m_valid is 1 and m_ready is 0, m_valid, m_data, m_addr, m_subch, m_nonincr and get_ptr hold their values. get_ptr moves past a data word only when that word is accepted.
- R9: Any other word outside a method gives err_code 3 (reserved command), and get_ptr moves past it.
- R10: hdr_shadow holds the last word read outside a method, and data_shadow holds the last data word read.
- R11: A nonzero err_code sets suspended. suspended stays set and no further reads are issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the decoder to fetch |
| stall | input | 1 | Downstream hold: no new fetch while high |
| put_ptr | input | 32 | Byte address where the written part of the buffer ends |
| buf_len | input | 32 | Buffer length in bytes |
| mem_rd_en | output | 1 | Word read request |
| mem_rd_addr | output | MEM_AW | Word address of the read (get_ptr bits MEM_AW+1:2) |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| m_valid | output | 1 | Method word offered |
| m_ready | input | 1 | Consumer accepts the offered word |
| m_addr | output | 13 | Method byte address |
| m_subch | output | 3 | Subchannel |
| m_nonincr | output | 1 | 1 for non-incrementing methods |
| m_data | output | 32 | Data word |
| get_ptr | output | 32 | Current get pointer (byte address) |
| err_code | output | 3 | 0 none, 1 call, 2 return, 3 reserved, 4 protection |
| suspended | output | 1 | Set by any error |
| sub_active | output | 1 | Subroutine in progress |
| hdr_shadow | output | 32 | Last word read outside a method |
| data_shadow | output | 32 | Last data word read |
| jmp_shadow | output | 32 | Address following the last jump word |
| data_count | output | 32 | Data words accepted since the last header |
| busy | output | 1 | A word is being read or offered |

## Verification
A fault in the decode of the word class shows up at the first control word or header that follows. It appears as a wrong get_ptr, a wrong err_code, or a missing or extra method word. A fault in the method state shows up on the next accepted data word, as a wrong m_addr, m_subch or m_nonincr, or as a wrong count of words before the next header. Subroutine faults show up one return later, as a return to the wrong place or a false return error. For this reason the bench compares every accepted word in order against a reference walk of the same buffer, and also compares the final pointer and the shadow registers.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;

  localparam int WORD_W  = 32;
  localparam int MADDR_W = 13;
  localparam int SUBCH_W = 3;
  localparam int COUNT_W = 11;
  localparam int DCNT_W  = 32;

  localparam logic [WORD_W-1:0] RET_WORD     = 32'h0002_0000;
  localparam logic [WORD_W-1:0] LJMP_MASK    = 32'hE000_0003;
  localparam logic [WORD_W-1:0] LJMP_MATCH   = 32'h2000_0000;
  localparam logic [WORD_W-1:0] HDR_MASK     = 32'hE003_0003;
  localparam logic [WORD_W-1:0] HDR_NONINC   = 32'h4000_0000;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_CALL = 3'd1,
    ERR_RET  = 3'd2,
    ERR_RSVD = 3'd3,
    ERR_PROT = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    CK_LJUMP, CK_JUMP, CK_CALL, CK_RET, CK_INC, CK_NONINC, CK_RSVD
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [WORD_W-1:0] w);
    if ((w & LJMP_MASK) == LJMP_MATCH) return CK_LJUMP;
    if (w[1:0] == 2'b01)               return CK_JUMP;
    if (w[1:0] == 2'b10)               return CK_CALL;
    if (w == RET_WORD)                 return CK_RET;
    if ((w & HDR_MASK) == '0)          return CK_INC;
    if ((w & HDR_MASK) == HDR_NONINC)  return CK_NONINC;
    return CK_RSVD;
  endfunction

  function automatic logic [WORD_W-1:0] branch_target(input logic [WORD_W-1:0] w,
                                                      input logic legacy);
    return legacy ? {3'b000, w[28:0]} : {w[31:2], 2'b00};
  endfunction

  function automatic logic [MADDR_W-1:0] hdr_maddr(input logic [WORD_W-1:0] w);
    return {w[MADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic [SUBCH_W-1:0] hdr_subch(input logic [WORD_W-1:0] w);
    return w[15:13];
  endfunction

  function automatic logic [COUNT_W-1:0] hdr_count(input logic [WORD_W-1:0] w);
    return w[28:18];
  endfunction

  function automatic logic [MADDR_W-1:0] step_maddr(input logic [MADDR_W-1:0] a,
                                                    input logic nonincr);
    return nonincr ? a : a + MADDR_W'(4);
  endfunction

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import cmdstream_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_kind_e         kind,
  output logic [WORD_W-1:0] target
);
  always_comb begin
    kind   = classify(word);
    target = branch_target(word, kind == CK_LJUMP);
  end
endmodule

// File: rtl/method_tracker.sv
module method_tracker
  import cmdstream_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WORD_W-1:0]  hdr_word,
  input  logic               load_nonincr,
  input  logic               step,
  output logic [MADDR_W-1:0] maddr,
  output logic [SUBCH_W-1:0] subch,
  output logic [COUNT_W-1:0] count,
  output logic               nonincr,
  output logic [DCNT_W-1:0]  dcount
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maddr   <= '0;
      subch   <= '0;
      count   <= '0;
      nonincr <= 1'b0;
      dcount  <= '0;
    end else if (load) begin
      maddr   <= hdr_maddr(hdr_word);
      subch   <= hdr_subch(hdr_word);
      count   <= hdr_count(hdr_word);
      nonincr <= load_nonincr;
      dcount  <= '0;
    end else if (step) begin
      maddr   <= step_maddr(maddr, nonincr);
      count   <= count - COUNT_W'(1);
      dcount  <= dcount + DCNT_W'(1);
    end
  end

  // R7: a data step only happens with words left in the method
  p_step_needs_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> count != '0);

  // R7: each accepted word removes exactly one from the count
  p_count_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> count == $past(count) - COUNT_W'(1));

  // R7: incrementing methods move the address forward by one word
  p_addr_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !nonincr |=> maddr == $past(maddr) + MADDR_W'(4));

  // R6: a header clears the accepted-word counter
  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dcount == '0);
endmodule

// File: rtl/cmdstream_decoder.sv
module cmdstream_decoder
  import cmdstream_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               stall,
  input  logic [WORD_W-1:0]  put_ptr,
  input  logic [WORD_W-1:0]  buf_len,
  output logic               mem_rd_en,
  output logic [MEM_AW-1:0]  mem_rd_addr,
  input  logic [WORD_W-1:0]  mem_rd_data,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [MADDR_W-1:0] m_addr,
  output logic [SUBCH_W-1:0] m_subch,
  output logic               m_nonincr,
  output logic [WORD_W-1:0]  m_data,
  output logic [WORD_W-1:0]  get_ptr,
  output logic [2:0]         err_code,
  output logic               suspended,
  output logic               sub_active,
  output logic [WORD_W-1:0]  hdr_shadow,
  output logic [WORD_W-1:0]  data_shadow,
  output logic [WORD_W-1:0]  jmp_shadow,
  output logic [DCNT_W-1:0]  data_count,
  output logic               busy
);
  localparam int WSTEP = WORD_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EMIT} st_e;

  st_e               state;
  logic [WORD_W-1:0] get_q, sub_ret_q, hdr_q, dat_q, jsh_q;
  logic              sub_act_q, susp_q;
  err_e              err_q;

  cmd_kind_e         kind;
  logic [WORD_W-1:0] target;
  logic [MADDR_W-1:0] trk_addr;
  logic [SUBCH_W-1:0] trk_subch;
  logic [COUNT_W-1:0] trk_count;
  logic               trk_nonincr;
  logic [DCNT_W-1:0]  trk_dcount;

  // named internal events
  logic go, out_of_range, fetch_fire, prot_fire;
  logic word_is_data, hdr_seen, hdr_load, emit_fire;
  logic [WORD_W-1:0] next_get;

  always_comb begin
    go           = (state == ST_IDLE) && enable && !stall && !susp_q && (get_q != put_ptr);
    out_of_range = get_q >= buf_len;
    fetch_fire   = go && !out_of_range;
    prot_fire    = go && out_of_range;
    word_is_data = (state == ST_READ) && (trk_count != '0);
    hdr_seen     = (state == ST_READ) && (trk_count == '0);
    hdr_load     = hdr_seen && ((kind == CK_INC) || (kind == CK_NONINC));
    emit_fire    = (state == ST_EMIT) && m_ready;
    next_get     = get_q + WORD_W'(WSTEP);
  end

  cmd_classify u_classify (
    .word   (mem_rd_data),
    .kind   (kind),
    .target (target)
  );

  method_tracker u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (hdr_load),
    .hdr_word     (mem_rd_data),
    .load_nonincr (kind == CK_NONINC),
    .step         (emit_fire),
    .maddr        (trk_addr),
    .subch        (trk_subch),
    .count        (trk_count),
    .nonincr      (trk_nonincr),
    .dcount       (trk_dcount)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      get_q     <= '0;
      sub_ret_q <= '0;
      sub_act_q <= 1'b0;
      hdr_q     <= '0;
      dat_q     <= '0;
      jsh_q     <= '0;
      susp_q    <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (prot_fire) begin
            err_q  <= ERR_PROT;
            susp_q <= 1'b1;
          end else if (fetch_fire) begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (word_is_data) begin
            dat_q <= mem_rd_data;
            state <= ST_EMIT;
          end else begin
            hdr_q <= mem_rd_data;
            state <= ST_IDLE;
            unique case (kind)
              CK_LJUMP, CK_JUMP: begin
                jsh_q <= next_get;
                get_q <= target;
              end
              CK_CALL: begin
                if (sub_act_q) begin
                  err_q  <= ERR_CALL;
                  susp_q <= 1'b1;
                end else begin
                  sub_ret_q <= next_get;
                  sub_act_q <= 1'b1;
                  get_q     <= target;
                end
              end
              CK_RET: begin
                if (!sub_act_q) begin
                  err_q  <= ERR_RET;
                  susp_q <= 1'b1;
                  get_q  <= next_get;
                end else begin
                  get_q     <= sub_ret_q;
                  sub_act_q <= 1'b0;
                end
              end
              CK_INC, CK_NONINC: get_q <= next_get;
              default: begin
                err_q  <= ERR_RSVD;
                susp_q <= 1'b1;
                get_q  <= next_get;
              end
            endcase
          end
        end
        ST_EMIT: begin
          if (emit_fire) begin
            get_q <= next_get;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = fetch_fire;
  assign mem_rd_addr = get_q[MEM_AW+1:2];
  assign m_valid     = (state == ST_EMIT);
  assign m_addr      = trk_addr;
  assign m_subch     = trk_subch;
  assign m_nonincr   = trk_nonincr;
  assign m_data      = dat_q;
  assign get_ptr     = get_q;
  assign err_code    = err_q;
  assign suspended   = susp_q;
  assign sub_active  = sub_act_q;
  assign hdr_shadow  = hdr_q;
  assign data_shadow = dat_q;
  assign jmp_shadow  = jsh_q;
  assign data_count  = trk_dcount;
  assign busy        = (state != ST_IDLE);

  // R2: no read while held off by the enable or stall inputs
  p_hold_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || !enable) |-> !mem_rd_en);

  // R2: an idle decoder with nothing to do leaves get alone
  p_idle_get_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (stall || !enable)) |=> $stable(get_ptr));

  // R8: an offered word holds until it is taken
  p_offer_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_addr)
                               && $stable(m_subch) && $stable(get_ptr)));

  // R11: suspension is sticky and blocks reads
  p_susp_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> suspended);
  p_susp_no_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_rd_en);
  p_susp_has_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> err_code != 3'd0);

  // R3: a protection fault keeps get where it was
  p_prot_get_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fire |=> (get_ptr == $past(get_ptr)) && (err_code == 3'd4));
endmodule

// File: tb/cmdstream_decoder_tb.sv
module cmdstream_decoder_tb;
  localparam int MEM_AW = 10;
  localparam int MEMW   = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] put_ptr = '0;
  logic [31:0] buf_len = 32'd4096;
  logic        mem_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [12:0] m_addr;
  logic [2:0]  m_subch;
  logic        m_nonincr;
  logic [31:0] m_data, get_ptr, hdr_shadow, data_shadow, jmp_shadow, data_count;
  logic [2:0]  err_code;
  logic        suspended, sub_active, busy;

  always #5 clk = ~clk;

  cmdstream_decoder #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stall(stall),
    .put_ptr(put_ptr), .buf_len(buf_len),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_subch(m_subch),
    .m_nonincr(m_nonincr), .m_data(m_data), .get_ptr(get_ptr),
    .err_code(err_code), .suspended(suspended), .sub_active(sub_active),
    .hdr_shadow(hdr_shadow), .data_shadow(data_shadow), .jmp_shadow(jmp_shadow),
    .data_count(data_count), .busy(busy)
  );

  logic [31:0] mem [0:MEMW-1];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // expected stream and final state from the bench reference walk
  logic [12:0] e_addr [0:4095];
  logic [2:0]  e_sub  [0:4095];
  logic        e_ni   [0:4095];
  logic [31:0] e_dat  [0:4095];
  int          n_exp, n_got;
  logic [31:0] x_get, x_hdr, x_dsh, x_jsh, x_dc;
  logic [2:0]  x_err;
  logic        x_sa;

  task automatic model_run();
    logic [31:0] g, w, ng, sr;
    logic [12:0] ma;
    logic [2:0]  sc;
    logic        ni, sa;
    logic [10:0] cnt;
    g = 0; ma = 0; sc = 0; ni = 0; sa = 0; sr = 0; cnt = 0;
    x_err = 0; x_hdr = 0; x_dsh = 0; x_jsh = 0; x_dc = 0; n_exp = 0;
    for (int s = 0; s < 4000; s++) begin
      if (g == put_ptr) break;
      if (g >= buf_len) begin x_err = 3'd4; break; end
      w  = mem[g[MEM_AW+1:2]];
      ng = g + 32'd4;
      if (cnt != 0) begin
        x_dsh = w;
        e_addr[n_exp] = ma; e_sub[n_exp] = sc; e_ni[n_exp] = ni; e_dat[n_exp] = w;
        n_exp++;
        cnt = cnt - 11'd1;
        x_dc = x_dc + 1;
        if (!ni) ma = ma + 13'd4;
        g = ng;
      end else begin
        x_hdr = w;
        if ((w & 32'hE0000003) == 32'h20000000) begin x_jsh = ng; g = w & 32'h1FFFFFFF; end
        else if (w[1:0] == 2'b01) begin x_jsh = ng; g = w & 32'hFFFFFFFC; end
        else if (w[1:0] == 2'b10) begin
          if (sa) begin x_err = 3'd1; break; end
          sr = ng; sa = 1'b1; g = w & 32'hFFFFFFFC;
        end else if (w == 32'h00020000) begin
          if (!sa) begin x_err = 3'd2; g = ng; break; end
          g = sr; sa = 1'b0;
        end else if ((w & 32'hE0030003) == 0 || (w & 32'hE0030003) == 32'h40000000) begin
          ma = w[12:0] & 13'h1FFC; sc = w[15:13]; cnt = w[28:18];
          ni = (w & 32'hE0030003) == 32'h40000000; x_dc = 0; g = ng;
        end else begin x_err = 3'd3; g = ng; break; end
      end
    end
    x_get = g; x_sa = sa;
  endtask

  // output monitor: ready pattern and stream comparison
  bit rand_rdy = 1'b0;
  bit mon_on = 1'b0;
  bit rd_seen = 1'b0;
  always @(negedge clk) begin
    if (mem_rd_en) rd_seen = 1'b1;
    m_ready = rand_rdy ? (($urandom % 3) != 0) : 1'b1;
    if (mon_on && m_valid && m_ready) begin
      if (n_got < n_exp) begin
        chk("R7 m_addr",    {19'd0, m_addr},    {19'd0, e_addr[n_got]});
        chk("R6 m_subch",   {29'd0, m_subch},   {29'd0, e_sub[n_got]});
        chk("R6 m_nonincr", {31'd0, m_nonincr}, {31'd0, e_ni[n_got]});
        chk("R7 m_data",    m_data,             e_dat[n_got]);
      end else chk("R7 extra word emitted", 32'd1, 32'd0);
      n_got++;
    end
  end

  function automatic logic [31:0] mk_hdr(input bit ni, input logic [2:0] sc,
                                         input logic [12:0] a, input logic [10:0] c);
    return (ni ? 32'h40000000 : 32'h0) | ({21'd0, c} << 18) | ({29'd0, sc} << 13)
           | {19'd0, a & 13'h1FFC};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < MEMW; i++) mem[i] = 32'hFFFF_FFFF;
  endtask

  task automatic do_reset();
    mon_on = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n_got = 0;
    rd_seen = 1'b0;
  endtask

  // run the decoder to completion and compare with the reference walk
  task automatic run_and_compare(input string name);
    int t;
    model_run();
    mon_on = 1'b1;
    enable = 1'b1;
    t = 0;
    @(negedge clk);
    while (!(!busy && (get_ptr == put_ptr || suspended)) && t < 5000) begin
      @(negedge clk); t++;
    end
    if (t >= 5000) chk({name, " R2 run did not finish"}, 32'd1, 32'd0);
    repeat (2) @(negedge clk);
    chk({name, " R2 final get"},      get_ptr,      x_get);
    chk({name, " R11 err_code"},      {29'd0, err_code}, {29'd0, x_err});
    chk({name, " R11 suspended"},     {31'd0, suspended}, {31'd0, (x_err != 0)});
    chk({name, " R5 sub_active"},     {31'd0, sub_active}, {31'd0, x_sa});
    chk({name, " R10 hdr_shadow"},    hdr_shadow,   x_hdr);
    chk({name, " R10 data_shadow"},   data_shadow,  x_dsh);
    chk({name, " R4 jmp_shadow"},     jmp_shadow,   x_jsh);
    chk({name, " R7 data_count"},     data_count,   x_dc);
    chk({name, " R7 word count"},     n_got,        n_exp);
    mon_on = 1'b0;
    enable = 1'b0;
  endtask

  task automatic build_random();
    int pos, k;
    logic [31:0] r;
    clear_mem();
    mem[384] = mk_hdr(1'b1, 3'd5, 13'h0100, 11'd2);
    mem[385] = $urandom;
    mem[386] = $urandom;
    mem[387] = 32'h0002_0000;
    pos = 0;
    while (pos < 200) begin
      r = $urandom % 8;
      if (r <= 4) begin
        k = $urandom % 4;
        mem[pos] = mk_hdr(r == 4, 3'($urandom), 13'($urandom), 11'(k));
        pos++;
        for (int i = 0; i < k; i++) begin mem[pos] = $urandom; pos++; end
      end else if (r == 5) begin
        k = 1 + $urandom % 3;
        if ($urandom % 2) mem[pos] = 32'h20000000 | ((pos + k + 1) * 4);
        else              mem[pos] = ((pos + k + 1) * 4) | 32'h1;
        pos = pos + k + 1;
      end else if (r == 6) begin
        mem[pos] = 32'h0000_0600 | 32'h2;
        pos++;
      end else begin
        mem[pos] = mk_hdr(1'b0, 3'd1, 13'h0040, 11'd0);
        pos++;
      end
    end
    put_ptr = pos * 4;
    buf_len = 32'd4096;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_mem();
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 get_ptr",   get_ptr,   32'd0);
    chk("R1 err_code",  {29'd0, err_code}, 32'd0);
    chk("R1 suspended", {31'd0, suspended}, 32'd0);
    chk("R1 m_valid",   {31'd0, m_valid}, 32'd0);
    chk("R1 busy",      {31'd0, busy}, 32'd0);
    chk("R1 data_count", data_count, 32'd0);

    // R2: enable low and stall high hold everything
    mem[0] = mk_hdr(1'b0, 3'd2, 13'h0200, 11'd2);
    mem[1] = 32'hAAAA_0001; mem[2] = 32'hAAAA_0002;
    put_ptr = 32'd12; buf_len = 32'd4096;
    repeat (10) @(negedge clk);
    chk("R2 get held with enable low", get_ptr, 32'd0);
    chk("R2 no read with enable low", {31'd0, rd_seen}, 32'd0);
    enable = 1'b1; stall = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 get held under stall", get_ptr, 32'd0);
    chk("R2 no read under stall", {31'd0, rd_seen}, 32'd0);
    stall = 1'b0; enable = 1'b0;
    run_and_compare("stall-release");

    // R9: reserved word after a method
    clear_mem(); do_reset();
    mem[0] = mk_hdr(1'b0, 3'd0, 13'h0010, 11'd1); mem[1] = 32'h1234_5678; mem[2] = 32'h0000_0003;
    put_ptr = 32'd16;
    run_and_compare("reserved");
    chk("R9 reserved code", {29'd0, err_code}, 32'd3);
    chk("R9 get past word", get_ptr, 32'd12);

    // R5: return with no subroutine
    clear_mem(); do_reset();
    mem[0] = 32'h0002_0000; put_ptr = 32'd16;
    run_and_compare("bad-return");
    chk("R5 return error", {29'd0, err_code}, 32'd2);
    chk("R5 get past return", get_ptr, 32'd4);

    // R5: call inside subroutine
    clear_mem(); do_reset();
    mem[0] = 32'h0000_0042; mem[16] = 32'h0000_0082; put_ptr = 32'h100;
    run_and_compare("nested-call");
    chk("R5 call error", {29'd0, err_code}, 32'd1);
    chk("R5 get stays on call", get_ptr, 32'h40);

    // R3: protection fault partway through a method
    clear_mem(); do_reset();
    mem[0] = mk_hdr(1'b0, 3'd3, 13'h0020, 11'd3);
    mem[1] = 32'hBEEF_0001; mem[2] = 32'hBEEF_0002; mem[3] = 32'hBEEF_0003;
    put_ptr = 32'd16; buf_len = 32'd8;
    run_and_compare("protection");
    chk("R3 protection code", {29'd0, err_code}, 32'd4);
    chk("R3 get unchanged", get_ptr, 32'd8);
    buf_len = 32'd4096;

    // R7: address wrap with backpressure (R8)
    clear_mem(); do_reset();
    rand_rdy = 1'b1;
    mem[0] = mk_hdr(1'b0, 3'd7, 13'h1FF8, 11'd3);
    mem[1] = 32'h1; mem[2] = 32'h2; mem[3] = 32'h3;
    put_ptr = 32'd16;
    run_and_compare("wrap");
    chk("R7 wrapped address", {19'd0, e_addr[2]}, 32'h0);

    // R4: legacy jump and normal jump
    clear_mem(); do_reset();
    mem[0] = 32'h2000_0100; mem[64] = 32'h0000_0201;
    mem[128] = mk_hdr(1'b1, 3'd4, 13'h0300, 11'd2);
    mem[129] = 32'hC0DE_0001; mem[130] = 32'hC0DE_0002;
    put_ptr = 32'd524;
    run_and_compare("jumps");
    chk("R4 jump shadow", jmp_shadow, 32'h104);

    // random programs with random ready
    for (int n = 0; n < 30; n++) begin
      build_random();
      do_reset();
      run_and_compare($sformatf("rand%0d", n));
    end
    rand_rdy = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    n_checks++; n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected<190000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule